// File: doc/BRIEF.md
# Comparator-Sorting Task Router

This block connects N task-side memory ports to N processor-side memory ports. The binding of tasks to processors is given as a set of tags. Each task port carries the number of the processor it should run on, plus a valid bit. The router does not look these bindings up in a central table. It builds a bitonic sorting network in which every 2x2 switch is a compare-exchange element. Once the tags are sorted into ascending order, output position p holds the task tagged p. Setting the data-path switches the same way as the comparators therefore delivers each task's traffic to its processor.

The switch settings are worked out one network stage per clock cycle, from the first stage to the last. During that time the configuration already in force stays registered and in use, so tasks whose binding does not change keep running while a new binding is prepared. When the last stage is resolved, the whole new configuration is applied in a single edge and the ready flag rises. Task ports left unbound are handed the unused processor numbers, so the sort always yields a full permutation. The data path itself is purely combinational.

Top module: `task_sort_router`

## Requirements
- R1: After reset, ready_o is 1, every bit of sw_cfg_o is 0, and processor port p carries the data of task port p for every p (identity routing).
- R2: The tag of task i is bind_tag_i[i*TW +: TW] (TW = log2 N). Once an update has finished, every task i with bind_vld_i[i] = 1 and tag p has its data on proc_data_o[p*DW +: DW]. This holds provided the valid tags are distinct.
- R3: Processor numbers not claimed by any valid tag go to the unbound task ports (bind_vld_i = 0). They are assigned in ascending numeric order to the unbound ports taken in ascending port index. Each such task's data then appears on the processor it received.
- R4: A request is accepted on a clock edge where upd_req_i = 1 and ready_o = 1. ready_o is 0 from that edge on. The new settings and ready_o = 1 appear together exactly NSTG edges later, where NSTG = log2N·(log2N+1)/2 (6 for N = 8).
- R5: While ready_o is 0, sw_cfg_o and the routing keep the previous configuration unchanged.
- R6: bind_tag_i, bind_vld_i and upd_req_i are ignored while ready_o is 0. The resulting routing reflects only the bindings present at the accepting edge.
- R7: A change on task_data_i reaches proc_data_o in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bind_tag_i | input | N*TW | Per-task processor number |
| bind_vld_i | input | N | Per-task binding valid |
| upd_req_i | input | 1 | Request to compute and apply a new binding |
| task_data_i | input | N*DW | Task-side memory interface data |
| proc_data_o | output | N*DW | Processor-side routed data |
| sw_cfg_o | output | NSTG*N/2 | Active switch settings, stage-major, 1 = exchange |
| ready_o | output | 1 | Idle with configuration applied |

## Verification
The bench builds the router with N = 8 and DW = 8. That gives six comparator stages of four switches each, covering block sizes 2, 4 and 8 in both sort directions. With this size the bench can apply a full reversal, a sparse binding that leaves processors idle with two unbound tasks, and a case where every task is unbound. The six-edge configuration window is also long enough to inject a competing request and altered tags in the middle of a computation and show that they have no effect.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    // Number of compare-exchange stages in a bitonic sorter of 2**logn ports
    function automatic int num_stages(input int logn);
        return (logn * (logn + 1)) / 2;
    endfunction

    // log2 of the merge block size handled by stage st
    function automatic int stg_log_blk(input int st, input int logn);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int p = 1; p <= logn; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (idx == st) res = p;
                idx++;
            end
        end
        return res;
    endfunction

    // log2 of the compare distance used by stage st
    function automatic int stg_log_dist(input int st, input int logn);
        int idx;
        int res;
        idx = 0;
        res = 0;
        for (int p = 1; p <= logn; p++) begin
            for (int q = p - 1; q >= 0; q--) begin
                if (idx == st) res = q;
                idx++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tsr_tag_fill.sv
module tsr_tag_fill #(
    parameter int N  = 8,
    parameter int TW = 3
) (
    input  logic [N*TW-1:0] tag_i,
    input  logic [N-1:0]    vld_i,
    output logic [N*TW-1:0] tag_o
);
    logic [N-1:0]  used;
    logic [TW-1:0] free_num [N];
    int            nfree;
    int            nunb;

    always_comb begin
        used = '0;
        for (int i = 0; i < N; i++) begin
            if (vld_i[i]) used[tag_i[i*TW +: TW]] = 1'b1;
        end
        nfree = 0;
        for (int p = 0; p < N; p++) free_num[p] = '0;
        for (int p = 0; p < N; p++) begin
            if (!used[p]) begin
                free_num[nfree] = TW'(p);
                nfree++;
            end
        end
        nunb = 0;
        tag_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vld_i[i]) begin
                tag_o[i*TW +: TW] = tag_i[i*TW +: TW];
            end else begin
                if (nunb < N) tag_o[i*TW +: TW] = free_num[nunb];
                nunb++;
            end
        end
    end

    // R3: an unbound port never receives a number that a valid tag claims
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (!vld_i[i] && nfree >= nunb)
                a_r3_fill_unclaimed: assert (!used[tag_o[i*TW +: TW]]);
        end
    end

endmodule

// File: rtl/tsr_cmp_stage.sv
module tsr_cmp_stage #(
    parameter int N    = 8,
    parameter int TW   = 3,
    parameter int SCW  = 3,
    localparam int LOGN = $clog2(N),
    localparam int HALF = N / 2
) (
    input  logic [N*TW-1:0] tag_i,
    input  logic [SCW-1:0]  stg_i,
    output logic [N*TW-1:0] tag_o,
    output logic [HALF-1:0] swap_o
);
    int            lk;
    int            lj;
    int            lo;
    int            hi;
    logic          asc;
    logic [TW-1:0] ta;
    logic [TW-1:0] tb;

    always_comb begin
        lk     = tsr_pkg::stg_log_blk(int'(stg_i), LOGN);
        lj     = tsr_pkg::stg_log_dist(int'(stg_i), LOGN);
        tag_o  = tag_i;
        swap_o = '0;
        lo     = 0;
        hi     = 0;
        asc    = 1'b1;
        ta     = '0;
        tb     = '0;
        for (int s = 0; s < HALF; s++) begin
            lo  = ((s >> lj) << (lj + 1)) | (s & ((1 << lj) - 1));
            hi  = lo + (1 << lj);
            asc = ((lo >> lk) & 1) == 0;
            ta  = tag_i[lo*TW +: TW];
            tb  = tag_i[hi*TW +: TW];
            swap_o[s] = asc ? (ta > tb) : (ta < tb);
            if (swap_o[s]) begin
                tag_o[lo*TW +: TW] = tb;
                tag_o[hi*TW +: TW] = ta;
            end
        end
    end

endmodule

// File: rtl/tsr_data_net.sv
module tsr_data_net #(
    parameter int N    = 8,
    parameter int DW   = 8,
    localparam int LOGN = $clog2(N),
    localparam int HALF = N / 2,
    localparam int NSTG = tsr_pkg::num_stages(LOGN),
    localparam int NSW  = NSTG * HALF
) (
    input  logic [N*DW-1:0] data_i,
    input  logic [NSW-1:0]  cfg_i,
    output logic [N*DW-1:0] data_o
);
    logic [N*DW-1:0] lvl [NSTG+1];

    assign lvl[0] = data_i;

    for (genvar st = 0; st < NSTG; st++) begin : g_stage
        localparam int LJ = tsr_pkg::stg_log_dist(st, LOGN);
        for (genvar s = 0; s < HALF; s++) begin : g_sw
            localparam int LO = ((s >> LJ) << (LJ + 1)) | (s & ((1 << LJ) - 1));
            localparam int HI = LO + (1 << LJ);
            logic x;
            assign x = cfg_i[st*HALF + s];
            assign lvl[st+1][LO*DW +: DW] = x ? lvl[st][HI*DW +: DW] : lvl[st][LO*DW +: DW];
            assign lvl[st+1][HI*DW +: DW] = x ? lvl[st][LO*DW +: DW] : lvl[st][HI*DW +: DW];
        end
    end

    assign data_o = lvl[NSTG];

endmodule

// File: rtl/task_sort_router.sv
module task_sort_router #(
    parameter int N    = 8,
    parameter int DW   = 8,
    localparam int TW   = $clog2(N),
    localparam int LOGN = $clog2(N),
    localparam int HALF = N / 2,
    localparam int NSTG = tsr_pkg::num_stages(LOGN),
    localparam int NSW  = NSTG * HALF,
    localparam int SCW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*TW-1:0] bind_tag_i,
    input  logic [N-1:0]    bind_vld_i,
    input  logic            upd_req_i,
    input  logic [N*DW-1:0] task_data_i,
    output logic [N*DW-1:0] proc_data_o,
    output logic [NSW-1:0]  sw_cfg_o,
    output logic            ready_o
);
    typedef struct packed {
        logic            busy;
        logic [SCW-1:0]  stg;
        logic [N*TW-1:0] tags;
        logic [NSW-1:0]  pend;
        logic [NSW-1:0]  act;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    logic [N*TW-1:0] filled;
    logic [N*TW-1:0] stage_out;
    logic [HALF-1:0] stage_swap;
    logic            last_stg;

    tsr_tag_fill #(.N(N), .TW(TW)) u_fill (
        .tag_i (bind_tag_i),
        .vld_i (bind_vld_i),
        .tag_o (filled)
    );

    tsr_cmp_stage #(.N(N), .TW(TW), .SCW(SCW)) u_cmp (
        .tag_i  (st_q.tags),
        .stg_i  (st_q.stg),
        .tag_o  (stage_out),
        .swap_o (stage_swap)
    );

    tsr_data_net #(.N(N), .DW(DW)) u_net (
        .data_i (task_data_i),
        .cfg_i  (st_q.act),
        .data_o (proc_data_o)
    );

    assign last_stg = (st_q.stg == SCW'(NSTG - 1));

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (upd_req_i) begin
                st_d.busy = 1'b1;
                st_d.stg  = '0;
                st_d.tags = filled;
                st_d.pend = '0;
            end
        end else begin
            st_d.tags = stage_out;
            st_d.pend[st_q.stg*HALF +: HALF] = stage_swap;
            if (last_stg) begin
                st_d.act  = st_d.pend;
                st_d.busy = 1'b0;
                st_d.stg  = '0;
            end else begin
                st_d.stg = st_q.stg + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_cfg_o = st_q.act;
    assign ready_o  = !st_q.busy;

    logic tags_sorted;
    always_comb begin
        tags_sorted = 1'b1;
        for (int i = 0; i + 1 < N; i++) begin
            if (st_q.tags[i*TW +: TW] > st_q.tags[(i+1)*TW +: TW]) tags_sorted = 1'b0;
        end
    end

    // R2: the comparator pass leaves the tags in ascending order at commit
    a_r2_sorted_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last_stg) |=> tags_sorted);

    // R4: an accepted request drops ready on the next edge
    a_r4_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && upd_req_i) |=> !ready_o);

    // R4: ready only returns after the final stage was evaluated
    a_r4_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(last_stg));

    // R5: the active settings never move while a computation is running
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last_stg) |=> $stable(sw_cfg_o));

    // R6: with ready low, nothing restarts the stage sequence
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last_stg) |=> (st_q.stg == $past(st_q.stg) + 1'b1));

endmodule

// File: tb/task_sort_router_tb.sv
`timescale 1ns/1ps
module task_sort_router_tb;
    localparam int N    = 8;
    localparam int DW   = 8;
    localparam int TW   = 3;
    localparam int NSTG = 6;
    localparam int NSW  = NSTG * N / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*TW-1:0] tag = '0;
    logic [N-1:0]    vld = '0;
    logic            req = 1'b0;
    logic [N*DW-1:0] tdata = '0;
    logic [N*DW-1:0] pdata;
    logic [NSW-1:0]  cfg;
    logic            rdy;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    task_sort_router #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bind_tag_i(tag), .bind_vld_i(vld),
        .upd_req_i(req), .task_data_i(tdata), .proc_data_o(pdata),
        .sw_cfg_o(cfg), .ready_o(rdy)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Expected routing from R2/R3
    function automatic logic [N*DW-1:0] expect_route(input logic [N*TW-1:0] t, input logic [N-1:0] v,
                                                    input logic [N*DW-1:0] d);
        logic [N-1:0] used = '0;
        int fr [N];
        int nf = 0;
        int nu = 0;
        logic [N*DW-1:0] r = '0;
        for (int i = 0; i < N; i++) if (v[i]) used[t[i*TW +: TW]] = 1'b1;
        for (int p = 0; p < N; p++) if (!used[p]) begin fr[nf] = p; nf++; end
        for (int i = 0; i < N; i++) begin
            int p;
            if (v[i]) p = int'(t[i*TW +: TW]);
            else begin p = fr[nu]; nu++; end
            r[p*DW +: DW] = d[i*DW +: DW];
        end
        return r;
    endfunction

    function automatic logic [N*DW-1:0] mkdata(input int seed);
        logic [N*DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'(seed * 16 + i * 7 + 1);
        return r;
    endfunction

    // Apply a binding, check latency, hold and final routing
    task automatic run_update(input logic [N*TW-1:0] t, input logic [N-1:0] v, input bit junk, input string rq);
        logic [NSW-1:0]  old_cfg;
        logic [N*DW-1:0] old_out;
        int lowcnt = 0;
        @(negedge clk);
        old_cfg = cfg;
        old_out = pdata;
        tag = t; vld = v; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (!rdy && lowcnt < 50) begin
            chk(cfg == old_cfg, "R5 cfg held", 64'(cfg), 64'(old_cfg));
            chk(pdata == old_out, "R5 routing held", pdata, old_out);
            if (junk && lowcnt == 2) begin
                req = 1'b1; tag = ~t; vld = ~v;
            end
            if (junk && lowcnt == 3) req = 1'b0;
            lowcnt++;
            @(negedge clk);
        end
        chk(lowcnt == NSTG, "R4 latency", 64'(lowcnt), 64'(NSTG));
        chk(pdata == expect_route(t, v, tdata), rq, pdata, expect_route(t, v, tdata));
        tag = t; vld = v;
    endtask

    task automatic t_reset;
        tdata = mkdata(1);
        #1;
        chk(rdy == 1'b1, "R1 ready", 64'(rdy), 64'd1);
        chk(cfg == '0, "R1 cfg zero", 64'(cfg), 64'd0);
        chk(pdata == tdata, "R1 identity", pdata, tdata);
    endtask

    task automatic t_reverse;
        logic [N*TW-1:0] t;
        for (int i = 0; i < N; i++) t[i*TW +: TW] = TW'(N - 1 - i);
        run_update(t, '1, 1'b0, "R2 reversal");
    endtask

    task automatic t_sparse;
        logic [N*TW-1:0] t = '0;
        logic [N-1:0]    v = '0;
        int procs [6] = '{1, 2, 3, 4, 5, 7};
        int ports [6] = '{4, 1, 3, 0, 7, 2};
        for (int k = 0; k < 6; k++) begin
            t[ports[k]*TW +: TW] = TW'(procs[k]);
            v[ports[k]] = 1'b1;
        end
        // unbound ports 5,6 take processors 0,6 (R3)
        run_update(t, v, 1'b0, "R3 sparse binding");
        chk(pdata[0*DW +: DW] == tdata[5*DW +: DW], "R3 port5->proc0", 64'(pdata[0 +: DW]), 64'(tdata[5*DW +: DW]));
        chk(pdata[6*DW +: DW] == tdata[6*DW +: DW], "R3 port6->proc6", 64'(pdata[6*DW +: DW]), 64'(tdata[6*DW +: DW]));
    endtask

    task automatic t_ignore;
        logic [N*TW-1:0] t;
        int perm [N] = '{3, 6, 0, 5, 1, 7, 2, 4};
        for (int i = 0; i < N; i++) t[i*TW +: TW] = TW'(perm[i]);
        run_update(t, '1, 1'b1, "R6 mid-run request ignored");
        @(negedge clk);
        chk(rdy == 1'b1, "R6 no second run", 64'(rdy), 64'd1);
    endtask

    task automatic t_data;
        logic [N*DW-1:0] e;
        @(negedge clk);
        tdata = mkdata(9);
        #1;
        e = expect_route(tag, vld, tdata);
        chk(pdata == e, "R7 same-cycle data", pdata, e);
    endtask

    task automatic t_all_unbound;
        run_update('0, '0, 1'b0, "R3 all unbound");
        chk(pdata == tdata, "R3 all unbound identity", pdata, tdata);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reverse();
        t_sparse();
        t_ignore();
        t_data();
        t_all_unbound();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

endmodule